// File: doc/BRIEF.md
# Loop Exit Predictor

This block sits beside a main direction predictor in an instruction fetch unit and learns how many times a loop-closing branch is taken before it falls through. It holds a small fully associative set of entries, each keyed by the full branch address. For every tracked branch it keeps a learned trip count, a confidence counter and two iteration counters. The committed counter follows resolved outcomes. The speculative counter follows the block's own predictions, so fetch can run ahead of resolution.

At fetch, the front end presents the address together with a flag that marks a backward conditional branch. The block returns a hit, a direction, and an override flag. The override flag tells the front end to use this direction instead of the main predictor's. When resolution reports a taken backward branch that no entry tracks, an entry is claimed in round-robin order. Each not-taken exit compares the committed count with the learned trip count. Overriding starts only after the same count has been seen at two consecutive exits.

Top module: `loopTermPredictor`

## Requirements
- R1: After reset no entry is valid: every fetch returns predHit, predOverride and predTaken all 0.
- R2: predHit is 1 only when fetchValid and fetchBackCond are both 1 and a valid entry holds exactly fetchPc. predTaken and predOverride are 0 whenever predHit is 0. A fetch without both flags leaves the speculative counter unchanged.
- R3: A resolution with resValid=1, resBackCond=1 and resTaken=1 whose resPc matches no entry claims one entry. The entry starts with committed and speculative counts of 1, trip count 0 and confidence 0. Victims rotate over the slots starting at slot 0, so the 33rd distinct address (with 32 slots) replaces the first.
- R4: Each tracked taken resolution adds 1 to the committed count. At a tracked not-taken resolution the count is compared with the trip count and then cleared to 0. A match raises the 2-bit confidence, saturating at 3. predOverride is 1 on a hit exactly when confidence is nonzero, so it first appears after two consecutive exits with the same count.
- R5: On a hit, predTaken is 1 while the speculative count is below the trip count. A taken prediction adds 1 to that count, and a not-taken prediction clears it to 0. A confident entry with trip count N therefore predicts N taken and then one not-taken, even across consecutive fetches with no resolution in between.
- R6: An exit whose count differs from the trip count stores the new count as the trip count and clears confidence to 0, which withdraws the override.
- R7: A resolution with resValid=1 and resMispredict=1 copies every entry's committed count, after this resolution's own update, into its speculative count.
- R8: A tracked resolution on an entry with confidence 0 copies that entry's updated committed count into its speculative count.
- R9: Committed counts are 10 bits wide. A tracked taken resolution that arrives when the count is already 1023 invalidates the entry.
- R10: A resolution with resBackCond=0 changes no entry and claims no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch lookup is presented |
| fetchBackCond | input | 1 | Fetched branch is conditional with negative displacement |
| fetchPc | input | 32 | Fetched branch address |
| predHit | output | 1 | Fetched branch is tracked |
| predOverride | output | 1 | Use predTaken instead of the main predictor |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| resValid | input | 1 | A branch resolution is presented |
| resBackCond | input | 1 | Resolved branch is conditional with negative displacement |
| resPc | input | 32 | Resolved branch address |
| resTaken | input | 1 | Actual outcome, 1 = taken |
| resMispredict | input | 1 | The front end's prediction for this branch was wrong |

## Verification
The hardest state to reach is a speculative counter that has moved away from its committed counter. That state exists only while fetches run ahead of resolutions, and the port outputs show it only through the position of the not-taken prediction. The bench makes several fetches of a trained loop with no resolution between them, then inserts one resolution, either flagged as a misprediction or on an entry that is not yet confident. It then reads out how many more taken predictions come before the exit, which reveals whether the counter was restored. Overflow is reached by driving 1023 taken resolutions into one entry before the one that invalidates it.

// File: rtl/ltpPkg.sv
package ltpPkg;
  // Strobes from the control to the entry bank; each applies to the
  // entry selected by the matching fetch or resolution vector.
  typedef struct packed {
    logic fetchAdv;     // speculative count +1 on fetch-hit entry
    logic fetchClr;     // speculative count to 0 on fetch-hit entry
    logic resInc;       // committed count +1 on resolve-hit entry
    logic resExitMatch; // exit with count equal to trip: confidence up
    logic resExitNew;   // exit with new count: store trip, clear confidence
    logic resKill;      // committed count overflow: invalidate entry
    logic resResync;    // copy committed into speculative on resolve-hit entry
    logic restoreAll;   // copy committed into speculative on every entry
    logic alloc;        // claim the slot named by the one-hot victim vector
  } ltpStrobes_t;
endpackage

// File: rtl/ltpEntryBank.sv
module ltpEntryBank
  import ltpPkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 10,
  parameter int CONF_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_W-1:0]     fetchPc,
  input  logic [PC_W-1:0]     resPc,
  input  ltpStrobes_t         strobes,
  input  logic [ENTRIES-1:0]  allocOneHot,
  output logic [ENTRIES-1:0]  fetchMatch,
  output logic [ENTRIES-1:0]  resMatch,
  output logic [CNT_W-1:0]    fetchSpec,
  output logic [CNT_W-1:0]    fetchTrip,
  output logic [CONF_W-1:0]   fetchConf,
  output logic [CNT_W-1:0]    resCommit,
  output logic [CNT_W-1:0]    resTrip,
  output logic [CONF_W-1:0]   resConf
);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  logic [CNT_W-1:0]  specArr   [ENTRIES];
  logic [CNT_W-1:0]  commitArr [ENTRIES];
  logic [CNT_W-1:0]  tripArr   [ENTRIES];
  logic [CONF_W-1:0] confArr   [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic              vld;
    logic [PC_W-1:0]   tag;
    logic [CNT_W-1:0]  commitCnt, specCnt, tripCnt, commitNext;
    logic [CONF_W-1:0] conf;

    assign fetchMatch[i] = vld && (tag == fetchPc);
    assign resMatch[i]   = vld && (tag == resPc);
    assign specArr[i]    = specCnt;
    assign commitArr[i]  = commitCnt;
    assign tripArr[i]    = tripCnt;
    assign confArr[i]    = conf;

    always_comb begin
      commitNext = commitCnt;
      if (resMatch[i]) begin
        if (strobes.resInc)
          commitNext = commitCnt + 1'b1;
        else if (strobes.resExitMatch || strobes.resExitNew)
          commitNext = '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld       <= 1'b0;
        tag       <= '0;
        commitCnt <= '0;
        specCnt   <= '0;
        tripCnt   <= '0;
        conf      <= '0;
      end else if (strobes.alloc && allocOneHot[i]) begin
        vld       <= 1'b1;
        tag       <= resPc;
        commitCnt <= CNT_W'(1);
        specCnt   <= CNT_W'(1);
        tripCnt   <= '0;
        conf      <= '0;
      end else begin
        commitCnt <= commitNext;
        if (resMatch[i] && strobes.resKill)
          vld <= 1'b0;
        if (resMatch[i] && strobes.resExitNew) begin
          tripCnt <= commitCnt;
          conf    <= '0;
        end else if (resMatch[i] && strobes.resExitMatch && conf != CONF_MAX) begin
          conf <= conf + 1'b1;
        end
        if (strobes.restoreAll || (resMatch[i] && strobes.resResync))
          specCnt <= commitNext;
        else if (fetchMatch[i] && strobes.fetchAdv)
          specCnt <= specCnt + 1'b1;
        else if (fetchMatch[i] && strobes.fetchClr)
          specCnt <= '0;
      end
    end
  end

  // One-hot selection of the matching entry's fields.
  always_comb begin
    fetchSpec = '0;
    fetchTrip = '0;
    fetchConf = '0;
    resCommit = '0;
    resTrip   = '0;
    resConf   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fetchMatch[i]) begin
        fetchSpec = fetchSpec | specArr[i];
        fetchTrip = fetchTrip | tripArr[i];
        fetchConf = fetchConf | confArr[i];
      end
      if (resMatch[i]) begin
        resCommit = resCommit | commitArr[i];
        resTrip   = resTrip | tripArr[i];
        resConf   = resConf | confArr[i];
      end
    end
  end
endmodule

// File: rtl/ltpControl.sv
module ltpControl
  import ltpPkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int CNT_W   = 10,
  parameter int CONF_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic               fetchBackCond,
  input  logic               resValid,
  input  logic               resBackCond,
  input  logic               resTaken,
  input  logic               resMispredict,
  input  logic [ENTRIES-1:0] fetchMatch,
  input  logic [ENTRIES-1:0] resMatch,
  input  logic [CNT_W-1:0]   fetchSpec,
  input  logic [CNT_W-1:0]   fetchTrip,
  input  logic [CONF_W-1:0]  fetchConf,
  input  logic [CNT_W-1:0]   resCommit,
  input  logic [CNT_W-1:0]   resTrip,
  input  logic [CONF_W-1:0]  resConf,
  output logic               predHit,
  output logic               predOverride,
  output logic               predTaken,
  output ltpStrobes_t        strobes,
  output logic [ENTRIES-1:0] allocOneHot
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic fetchHit, fetchGoTaken, resAct, resHit, resAtMax, resSameTrip;

  assign fetchHit     = fetchValid && fetchBackCond && (|fetchMatch);
  assign fetchGoTaken = fetchSpec < fetchTrip;
  assign predHit      = fetchHit;
  assign predTaken    = fetchHit && fetchGoTaken;
  assign predOverride = fetchHit && (fetchConf != '0);

  assign resAct      = resValid && resBackCond;
  assign resHit      = resAct && (|resMatch);
  assign resAtMax    = resCommit == CNT_MAX;
  assign resSameTrip = resCommit == resTrip;

  always_comb begin
    strobes              = '0;
    strobes.fetchAdv     = fetchHit && fetchGoTaken;
    strobes.fetchClr     = fetchHit && !fetchGoTaken;
    strobes.resInc       = resHit && resTaken && !resAtMax;
    strobes.resKill      = resHit && resTaken && resAtMax;
    strobes.resExitMatch = resHit && !resTaken && resSameTrip;
    strobes.resExitNew   = resHit && !resTaken && !resSameTrip;
    strobes.resResync    = resHit && (resConf == '0);
    strobes.restoreAll   = resValid && resMispredict;
    strobes.alloc        = resAct && resTaken && !(|resMatch);
  end

  always_comb begin
    allocOneHot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (strobes.alloc && (rrPtr == IDX_W'(i)))
        allocOneHot[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rrPtr <= '0;
    else if (strobes.alloc)
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/loopTermPredictor.sv
module loopTermPredictor
  import ltpPkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 10,
  parameter int CONF_W  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic            fetchBackCond,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predHit,
  output logic            predOverride,
  output logic            predTaken,
  input  logic            resValid,
  input  logic            resBackCond,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic            resMispredict
);
  ltpStrobes_t        strobes;
  logic [ENTRIES-1:0] fetchMatch, resMatch, allocOneHot;
  logic [CNT_W-1:0]   fetchSpec, fetchTrip, resCommit, resTrip;
  logic [CONF_W-1:0]  fetchConf, resConf;

  ltpEntryBank #(
    .ENTRIES(ENTRIES), .PC_W(PC_W), .CNT_W(CNT_W), .CONF_W(CONF_W)
  ) uBank (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .resPc(resPc),
    .strobes(strobes), .allocOneHot(allocOneHot),
    .fetchMatch(fetchMatch), .resMatch(resMatch),
    .fetchSpec(fetchSpec), .fetchTrip(fetchTrip), .fetchConf(fetchConf),
    .resCommit(resCommit), .resTrip(resTrip), .resConf(resConf)
  );

  ltpControl #(
    .ENTRIES(ENTRIES), .CNT_W(CNT_W), .CONF_W(CONF_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchBackCond(fetchBackCond),
    .resValid(resValid), .resBackCond(resBackCond),
    .resTaken(resTaken), .resMispredict(resMispredict),
    .fetchMatch(fetchMatch), .resMatch(resMatch),
    .fetchSpec(fetchSpec), .fetchTrip(fetchTrip), .fetchConf(fetchConf),
    .resCommit(resCommit), .resTrip(resTrip), .resConf(resConf),
    .predHit(predHit), .predOverride(predOverride), .predTaken(predTaken),
    .strobes(strobes), .allocOneHot(allocOneHot)
  );
endmodule

// File: rtl/ltpChecker.sv
module ltpChecker #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               fetchValid,
  input logic               fetchBackCond,
  input logic               predHit,
  input logic               predOverride,
  input logic               predTaken,
  input logic [ENTRIES-1:0] fetchMatch,
  input logic [ENTRIES-1:0] resMatch,
  input logic [ENTRIES-1:0] allocOneHot
);
  a_r2_hit_needs_flags: assert property (@(posedge clk) disable iff (!rstN)
    predHit |-> (fetchValid && fetchBackCond));

  a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> predHit);

  a_r4_override_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    predOverride |-> predHit);

  // R3: claiming only on a miss keeps every address in at most one slot
  a_r3_unique_fetch_tag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fetchMatch));

  a_r3_unique_res_tag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resMatch));

  a_r3_single_victim: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allocOneHot));
endmodule

bind loopTermPredictor ltpChecker #(.ENTRIES(ENTRIES)) uChk (
  .clk(clk), .rstN(rstN),
  .fetchValid(fetchValid), .fetchBackCond(fetchBackCond),
  .predHit(predHit), .predOverride(predOverride), .predTaken(predTaken),
  .fetchMatch(fetchMatch), .resMatch(resMatch), .allocOneHot(allocOneHot)
);

// File: tb/loopTermPredictor_test.sv
module loopTermPredictor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0, fetchBackCond = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predHit, predOverride, predTaken;
  logic        resValid = 1'b0, resBackCond = 1'b0, resTaken = 1'b0, resMispredict = 1'b0;
  logic [31:0] resPc = '0;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loopTermPredictor uut (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchBackCond(fetchBackCond), .fetchPc(fetchPc),
    .predHit(predHit), .predOverride(predOverride), .predTaken(predTaken),
    .resValid(resValid), .resBackCond(resBackCond), .resPc(resPc),
    .resTaken(resTaken), .resMispredict(resMispredict)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic fetchOp(input logic [31:0] pc, input logic back, input logic vld,
                         output logic h, output logic o, output logic t);
    @(negedge clk);
    fetchValid = vld; fetchBackCond = back; fetchPc = pc;
    #1 h = predHit; o = predOverride; t = predTaken;
    @(posedge clk); #1;
    fetchValid = 1'b0; fetchBackCond = 1'b0;
  endtask

  task automatic resolveOp(input logic [31:0] pc, input logic back, input logic tk, input logic mis);
    @(negedge clk);
    resValid = 1'b1; resBackCond = back; resPc = pc; resTaken = tk; resMispredict = mis;
    @(posedge clk); #1;
    resValid = 1'b0; resBackCond = 1'b0; resMispredict = 1'b0;
  endtask

  // One loop execution: trips taken iterations then the exit; the main
  // predictor is assumed to always say taken.
  task automatic runLoop(input logic [31:0] pc, input int trips, output int misCnt, output int ovrCnt);
    logic h, o, t, used, actual;
    misCnt = 0; ovrCnt = 0;
    for (int k = 0; k <= trips; k++) begin
      actual = (k < trips);
      fetchOp(pc, 1'b1, 1'b1, h, o, t);
      used = o ? t : 1'b1;
      if (o) ovrCnt++;
      if (used != actual) misCnt++;
      resolveOp(pc, 1'b1, actual, used != actual);
    end
  endtask

  task automatic train(input logic [31:0] pc, input int trips);
    int m, o;
    for (int r = 0; r < 3; r++) runLoop(pc, trips, m, o);
  endtask

  task automatic testReset();
    logic h, o, t;
    doReset();
    fetchOp(32'h0000_4000, 1'b1, 1'b1, h, o, t);
    check("R1", "hit after reset", h, 0);
    check("R1", "override after reset", o, 0);
    check("R1", "taken after reset", t, 0);
  endtask

  task automatic testRoundRobin();
    logic h, o, t;
    doReset();
    for (int k = 0; k < 32; k++) resolveOp(32'h1000 + k * 16, 1'b1, 1'b1, 1'b0);
    fetchOp(32'h1000, 1'b1, 1'b1, h, o, t);
    check("R3", "first claimed slot hits", h, 1);
    check("R3", "fresh entry not confident", o, 0);
    resolveOp(32'h9000, 1'b1, 1'b1, 1'b0);
    fetchOp(32'h1000, 1'b1, 1'b1, h, o, t);
    check("R3", "oldest address evicted", h, 0);
    fetchOp(32'h1010, 1'b1, 1'b1, h, o, t);
    check("R3", "second address kept", h, 1);
    fetchOp(32'h9000, 1'b1, 1'b1, h, o, t);
    check("R3", "new address tracked", h, 1);
  endtask

  task automatic testLearn();
    int m, ov;
    logic h, o, t;
    logic [31:0] pc = 32'h2000;
    doReset();
    runLoop(pc, 4, m, ov);
    check("R4", "overrides in first run", ov, 0);
    runLoop(pc, 4, m, ov);
    check("R4", "overrides in second run", ov, 0);
    runLoop(pc, 4, m, ov);
    check("R4", "overrides in third run", ov, 5);
    check("R5", "mispredicts in third run", m, 0);
    // R2: lookups without both flags see nothing and leave state alone
    fetchOp(pc, 1'b0, 1'b1, h, o, t);
    check("R2", "hit without backward flag", h, 0);
    check("R2", "override without backward flag", o, 0);
    fetchOp(pc, 1'b1, 1'b0, h, o, t);
    check("R2", "hit without valid", h, 0);
    runLoop(pc, 4, m, ov);
    check("R2", "mispredicts after ignored lookups", m, 0);
    // R10: resolutions without the backward flag are ignored
    resolveOp(pc, 1'b0, 1'b1, 1'b0);
    resolveOp(32'h7000, 1'b0, 1'b1, 1'b0);
    runLoop(pc, 4, m, ov);
    check("R10", "mispredicts after ignored resolution", m, 0);
    fetchOp(pc, 1'b1, 1'b1, h, o, t);
    check("R10", "confidence kept", o, 1);
    fetchOp(32'h7000, 1'b1, 1'b1, h, o, t);
    check("R10", "no claim for forward branch", h, 0);
  endtask

  task automatic testTripChange();
    int m, ov;
    logic h, o, t;
    logic [31:0] pc = 32'h3000;
    doReset();
    train(pc, 4);
    runLoop(pc, 6, m, ov);
    check("R6", "mispredicts on longer run", m, 2);
    fetchOp(pc, 1'b1, 1'b1, h, o, t);
    check("R6", "override withdrawn", o, 0);
    check("R6", "still tracked", h, 1);
    runLoop(pc, 6, m, ov);
    runLoop(pc, 6, m, ov);
    check("R6", "overrides with new trip", ov, 7);
    check("R6", "mispredicts with new trip", m, 0);
  endtask

  task automatic testRestore();
    logic h, o, t;
    int seq;
    logic [31:0] pc = 32'h5000;
    doReset();
    train(pc, 4);
    fetchOp(pc, 1'b1, 1'b1, h, o, t);
    fetchOp(pc, 1'b1, 1'b1, h, o, t);
    resolveOp(pc, 1'b1, 1'b1, 1'b1);
    seq = 0;
    for (int k = 0; k < 4; k++) begin
      fetchOp(pc, 1'b1, 1'b1, h, o, t);
      seq = (seq << 1) | int'(t);
    end
    check("R7", "taken pattern after restore (1110)", seq, 4'b1110);
  endtask

  task automatic testResync();
    int m, ov, seq;
    logic h, o, t;
    logic [31:0] pc = 32'h6000;
    doReset();
    runLoop(pc, 4, m, ov);
    for (int k = 0; k < 3; k++) fetchOp(pc, 1'b1, 1'b1, h, o, t);
    resolveOp(pc, 1'b1, 1'b1, 1'b0);
    seq = 0;
    for (int k = 0; k < 4; k++) begin
      fetchOp(pc, 1'b1, 1'b1, h, o, t);
      seq = (seq << 1) | int'(t);
    end
    check("R8", "taken pattern after resync (1110)", seq, 4'b1110);
    check("R8", "not confident", o, 0);
  endtask

  task automatic testOverflow();
    logic h, o, t;
    logic [31:0] pc = 32'h8000;
    doReset();
    for (int k = 0; k < 1023; k++) resolveOp(pc, 1'b1, 1'b1, 1'b0);
    fetchOp(pc, 1'b1, 1'b1, h, o, t);
    check("R9", "tracked at count 1023", h, 1);
    resolveOp(pc, 1'b1, 1'b1, 1'b0);
    fetchOp(pc, 1'b1, 1'b1, h, o, t);
    check("R9", "invalid after overflow", h, 0);
    resolveOp(pc, 1'b1, 1'b1, 1'b0);
    fetchOp(pc, 1'b1, 1'b1, h, o, t);
    check("R9", "reclaimed after overflow", h, 1);
  endtask

  initial begin
    testReset();
    testRoundRobin();
    testLearn();
    testTripChange();
    testRestore();
    testResync();
    testOverflow();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule